// File: doc/BRIEF.md
# Switch Configuration Register Read Responder

This block sits behind a switch's input port and answers configuration register reads. Requests and replies travel as token streams. Every token is an 8-bit value with a flag beside it that marks it as a control token or a data byte. The block checks each request step by step. It records where the answer should go and which register is wanted, then looks up a small bank of stand-in registers. A framed reply goes out on the output stream, which honours backpressure.

The parser walks through these states in order: `PS_HDR_HI`, `PS_HDR_LO`, `PS_CFG`, `PS_RDOP`, `PS_CORE_HI`, `PS_CORE_LO`, `PS_CHAN`, `PS_ADDR_HI`, `PS_ADDR_LO` and `PS_TAIL`. Each accepted token that fits the current state moves it on by one. A terminator accepted in `PS_TAIL` launches the reply and moves the parser to `PS_WAIT`. The parser leaves `PS_WAIT` for `PS_HDR_HI` once the reply's terminator has been sent.

A token that does not fit the current state is handled in one of two ways. If it is a terminator, the parser returns straight to `PS_HDR_HI`. If it is anything else, the parser enters `PS_SKIP`. `PS_SKIP` stays put until a terminator arrives, then returns to `PS_HDR_HI`.

The reply sequencer has its own states. It runs `RS_IDLE` to `RS_HDR` (three bytes), then `RS_ACK`, then `RS_WORD` (four bytes), then `RS_TAIL`, and back to `RS_IDLE`. It steps only when an output handshake occurs.

Top module: `swctl_read_handler`

## Requirements
- R1: The flag bit tells control tokens (flag 1) from data bytes (flag 0). A byte whose value matches a control code but whose flag is 0 is data. Such a byte is echoed unchanged when it appears in an identifier field. It does not count as a control token in a control position.
- R2: The block accepts a request of exactly this form. Two data header bytes come first. Next is a control token, either 0xC2 (processor-switch configuration) or 0xC3 (system-switch configuration). Then comes control token 0xC1 (read register). After that come the reply core id as two data bytes (high byte first), the reply channel as one data byte, and the register address as two data bytes (bits 15..8, then 7..0). A terminator control token (END_CODE, default 0x01) closes the request.
- R3: The reply is exactly nine tokens. First come the core id high byte, the core id low byte and the channel byte, all as data tokens copied from the request. Then comes the acknowledge control token (ACK_CODE, default 0x03). Then the 32-bit register value follows as four data bytes, bits 31..24 first and bits 7..0 last. The terminator control token ends the reply.
- R4: Register i, for i below NUM_REGS (default 8), reads REG_SEED + i*REG_STEP, taken modulo 2^32. The defaults are 0xA5C30F10 for REG_SEED and 0x01020311 for REG_STEP.
- R5: A 16-bit address at or above NUM_REGS reads as zero. This includes any address whose high byte is nonzero.
- R6: An unexpected token at any step discards the request, and no reply is sent. A missing terminator is one such case. If the offending token is itself a terminator, the next token starts a new request. Otherwise all tokens up to and including the next terminator are dropped.
- R7: Control token 0xC0 (write register), or any control token other than 0xC1, in the read-operation position counts as an unexpected token under R6.
- R8: While out_valid is high and out_ready is low, out_valid, out_ctl and out_data hold their values.
- R9: in_ready is low from the cycle after a request's terminator is accepted until the reply's terminator has been handed over. in_ready is high again in the following cycle.
- R10: Synchronous active-high reset puts out_valid low and in_ready high. It drops any reply in progress and returns the parser to `PS_HDR_HI`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted when high with in_valid |
| in_ctl | input | 1 | Input token is a control token |
| in_data | input | 8 | Input token value |
| out_valid | output | 1 | Output token valid |
| out_ready | input | 1 | Downstream takes the output token |
| out_ctl | output | 1 | Output token is a control token |
| out_data | output | 8 | Output token value |

## Verification
The bound checker watches the block on every cycle. It confirms that the output token holds steady under backpressure and that input is refused while a reply is pending. It also checks the reply framing: a handshake counter places the acknowledge in the fourth slot, the terminator in the ninth, and data tokens everywhere else. It checks the state that follows reset as well. Only the bench scenarios can show the content of a reply: the echoed identifiers, the register values and zeros for addresses out of range. The bench also shows that malformed requests produce no reply and that the parser resynchronises at a terminator.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    localparam logic [7:0] TOK_WRREG    = 8'hC0;
    localparam logic [7:0] TOK_RDREG    = 8'hC1;
    localparam logic [7:0] TOK_PROC_CFG = 8'hC2;
    localparam logic [7:0] TOK_SYS_CFG  = 8'hC3;

    typedef enum logic [3:0] {
        PS_HDR_HI, PS_HDR_LO, PS_CFG, PS_RDOP, PS_CORE_HI, PS_CORE_LO,
        PS_CHAN, PS_ADDR_HI, PS_ADDR_LO, PS_TAIL, PS_SKIP, PS_WAIT
    } prs_state_e;

    typedef enum logic [2:0] {
        RS_IDLE, RS_HDR, RS_ACK, RS_WORD, RS_TAIL
    } rsp_state_e;
endpackage

// File: rtl/swctl_req_parser.sv
module swctl_req_parser
    import swctl_pkg::*;
#(
    parameter logic [7:0] END_CODE = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_ctl,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        seq_done,
    output logic        req_go,
    output logic [15:0] core_id,
    output logic [7:0]  chan_id,
    output logic [15:0] reg_addr
);
    prs_state_e state, nxt;
    logic fire, is_end, is_dat, cfg_ok, rd_ok;
    prs_state_e bad_nxt;

    assign fire    = in_valid && in_ready;
    assign is_end  = in_ctl && (in_data == END_CODE);
    assign is_dat  = !in_ctl;
    assign cfg_ok  = in_ctl && (in_data == TOK_PROC_CFG || in_data == TOK_SYS_CFG);
    assign rd_ok   = in_ctl && (in_data == TOK_RDREG);
    assign bad_nxt = is_end ? PS_HDR_HI : PS_SKIP;

    always_ff @(posedge clk) begin
        if (rst) state <= PS_HDR_HI;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PS_HDR_HI:  if (fire) nxt = is_dat ? PS_HDR_LO  : bad_nxt;
            PS_HDR_LO:  if (fire) nxt = is_dat ? PS_CFG     : bad_nxt;
            PS_CFG:     if (fire) nxt = cfg_ok ? PS_RDOP    : bad_nxt;
            PS_RDOP:    if (fire) nxt = rd_ok  ? PS_CORE_HI : bad_nxt;
            PS_CORE_HI: if (fire) nxt = is_dat ? PS_CORE_LO : bad_nxt;
            PS_CORE_LO: if (fire) nxt = is_dat ? PS_CHAN    : bad_nxt;
            PS_CHAN:    if (fire) nxt = is_dat ? PS_ADDR_HI : bad_nxt;
            PS_ADDR_HI: if (fire) nxt = is_dat ? PS_ADDR_LO : bad_nxt;
            PS_ADDR_LO: if (fire) nxt = is_dat ? PS_TAIL    : bad_nxt;
            PS_TAIL:    if (fire) nxt = is_end ? PS_WAIT    : PS_SKIP;
            PS_SKIP:    if (fire && is_end) nxt = PS_HDR_HI;
            PS_WAIT:    if (seq_done) nxt = PS_HDR_HI;
            default:    nxt = PS_HDR_HI;
        endcase
    end

    always_comb begin
        in_ready = (state != PS_WAIT);
        req_go   = (state == PS_TAIL) && fire && is_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_id  <= '0;
            chan_id  <= '0;
            reg_addr <= '0;
        end else if (fire && is_dat) begin
            if (state == PS_CORE_HI) core_id[15:8]  <= in_data;
            if (state == PS_CORE_LO) core_id[7:0]   <= in_data;
            if (state == PS_CHAN)    chan_id        <= in_data;
            if (state == PS_ADDR_HI) reg_addr[15:8] <= in_data;
            if (state == PS_ADDR_LO) reg_addr[7:0]  <= in_data;
        end
    end
endmodule

// File: rtl/swctl_reg_bank.sv
module swctl_reg_bank #(
    parameter int          NUM_REGS = 8,
    parameter logic [31:0] REG_SEED = 32'hA5C3_0F10,
    parameter logic [31:0] REG_STEP = 32'h0102_0311
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] rd_addr,
    output logic [31:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [31:0] bank [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [31:0] INIT = REG_SEED + 32'(i) * REG_STEP;
        always_ff @(posedge clk) begin
            if (rst) bank[i] <= INIT;
        end
    end

    always_comb begin
        if (32'(rd_addr) < 32'(NUM_REGS)) rd_data = bank[rd_addr[IDX_W-1:0]];
        else                              rd_data = '0;
    end
endmodule

// File: rtl/swctl_reply_seq.sv
module swctl_reply_seq
    import swctl_pkg::*;
#(
    parameter logic [7:0] ACK_CODE = 8'h03,
    parameter logic [7:0] END_CODE = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic [15:0] core_id,
    input  logic [7:0]  chan_id,
    input  logic [31:0] rd_data,
    input  logic        out_ready,
    output logic        out_valid,
    output logic        out_ctl,
    output logic [7:0]  out_data,
    output logic        done
);
    rsp_state_e  state;
    logic [1:0]  cnt;
    logic [15:0] core_q;
    logic [7:0]  chan_q;
    logic [31:0] word_q;
    logic        adv;

    assign adv = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RS_IDLE;
            cnt    <= '0;
            core_q <= '0;
            chan_q <= '0;
            word_q <= '0;
        end else begin
            unique case (state)
                RS_IDLE: if (go) begin
                    state  <= RS_HDR;
                    cnt    <= '0;
                    core_q <= core_id;
                    chan_q <= chan_id;
                    word_q <= rd_data;
                end
                RS_HDR: if (adv) begin
                    if (cnt == 2'd2) begin state <= RS_ACK; cnt <= '0; end
                    else cnt <= cnt + 2'd1;
                end
                RS_ACK: if (adv) begin state <= RS_WORD; cnt <= '0; end
                RS_WORD: if (adv) begin
                    if (cnt == 2'd3) state <= RS_TAIL;
                    cnt <= cnt + 2'd1;
                end
                RS_TAIL: if (adv) state <= RS_IDLE;
                default: state <= RS_IDLE;
            endcase
        end
    end

    always_comb begin
        out_valid = (state != RS_IDLE);
        out_ctl   = 1'b0;
        out_data  = 8'h00;
        done      = (state == RS_TAIL) && out_ready;
        unique case (state)
            RS_IDLE: out_data = 8'h00;
            RS_HDR: begin
                unique case (cnt)
                    2'd0:    out_data = core_q[15:8];
                    2'd1:    out_data = core_q[7:0];
                    default: out_data = chan_q;
                endcase
            end
            RS_ACK: begin out_ctl = 1'b1; out_data = ACK_CODE; end
            RS_WORD: begin
                unique case (cnt)
                    2'd0:    out_data = word_q[31:24];
                    2'd1:    out_data = word_q[23:16];
                    2'd2:    out_data = word_q[15:8];
                    default: out_data = word_q[7:0];
                endcase
            end
            RS_TAIL: begin out_ctl = 1'b1; out_data = END_CODE; end
            default: out_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/swctl_read_handler.sv
module swctl_read_handler #(
    parameter int          NUM_REGS = 8,
    parameter logic [7:0]  ACK_CODE = 8'h03,
    parameter logic [7:0]  END_CODE = 8'h01,
    parameter logic [31:0] REG_SEED = 32'hA5C3_0F10,
    parameter logic [31:0] REG_STEP = 32'h0102_0311
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_ctl,
    input  logic [7:0] in_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       out_ctl,
    output logic [7:0] out_data
);
    logic        req_go, seq_done;
    logic [15:0] core_id, reg_addr;
    logic [7:0]  chan_id;
    logic [31:0] rd_data;

    swctl_req_parser #(.END_CODE(END_CODE)) parser_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctl(in_ctl),
        .in_data(in_data), .in_ready(in_ready), .seq_done(seq_done),
        .req_go(req_go), .core_id(core_id), .chan_id(chan_id),
        .reg_addr(reg_addr)
    );

    swctl_reg_bank #(.NUM_REGS(NUM_REGS), .REG_SEED(REG_SEED), .REG_STEP(REG_STEP)) bank_i (
        .clk(clk), .rst(rst), .rd_addr(reg_addr), .rd_data(rd_data)
    );

    swctl_reply_seq #(.ACK_CODE(ACK_CODE), .END_CODE(END_CODE)) seq_i (
        .clk(clk), .rst(rst), .go(req_go), .core_id(core_id),
        .chan_id(chan_id), .rd_data(rd_data), .out_ready(out_ready),
        .out_valid(out_valid), .out_ctl(out_ctl), .out_data(out_data),
        .done(seq_done)
    );
endmodule

// File: rtl/swctl_read_handler_chk.sv
module swctl_read_handler_chk #(
    parameter logic [7:0] ACK_CODE = 8'h03,
    parameter logic [7:0] END_CODE = 8'h01
) (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_ctl,
    input logic [7:0] out_data
);
    logic [3:0] slot;
    logic       hs;

    assign hs = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst)     slot <= '0;
        else if (hs) slot <= (slot == 4'd8) ? 4'd0 : slot + 4'd1;
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ctl) && $stable(out_data)));

    a_r9_no_accept_in_reply: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r3_ack_slot: assert property (@(posedge clk) disable iff (rst)
        (hs && slot == 4'd3) |-> (out_ctl && out_data == ACK_CODE));

    a_r3_end_slot: assert property (@(posedge clk) disable iff (rst)
        (hs && slot == 4'd8) |-> (out_ctl && out_data == END_CODE));

    a_r3_data_slots: assert property (@(posedge clk) disable iff (rst)
        (hs && slot != 4'd3 && slot != 4'd8) |-> !out_ctl);

    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));
endmodule

bind swctl_read_handler swctl_read_handler_chk #(.ACK_CODE(ACK_CODE), .END_CODE(END_CODE)) chk_i (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_ctl(out_ctl), .out_data(out_data)
);

// File: tb/swctl_read_handler_tb_top.sv
module swctl_read_handler_tb_top;
    localparam int          NREG = 8;
    localparam logic [7:0]  ACK  = 8'h03;
    localparam logic [7:0]  ENDT = 8'h01;
    localparam logic [31:0] SEED = 32'hA5C3_0F10;
    localparam logic [31:0] STEP = 32'h0102_0311;

    // {cfg, core, chan, addr, ready pattern}
    localparam int NV = 6;
    localparam logic [55:0] VEC [NV] = '{
        {8'hC2, 16'h1234, 8'h05, 16'h0000, 8'hFF},
        {8'hC3, 16'hABCD, 8'h7F, 16'h0007, 8'hAA},
        {8'hC2, 16'h00FF, 8'h00, 16'h0003, 8'h93},
        {8'hC3, 16'hC1C3, 8'hC0, 16'h0008, 8'hFF},
        {8'hC2, 16'h8001, 8'h01, 16'h0100, 8'h55},
        {8'hC3, 16'h0003, 8'h03, 16'h0005, 8'hCC}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_ctl = 1'b0, out_ready = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid, out_ctl;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    logic [8:0] got [9];
    int ngot;

    always #2 clk = ~clk;

    swctl_read_handler dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctl(in_ctl), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_ctl(out_ctl), .out_data(out_data)
    );

    function automatic logic [31:0] exp_reg(input logic [15:0] a);
        if (32'(a) < NREG) return SEED + 32'(a) * STEP;
        return 32'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_tok(input logic c, input logic [7:0] d);
        in_valid = 1'b1; in_ctl = c; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_ctl = 1'b0;
    endtask

    task automatic send_req(input logic [7:0] cfg, input logic cfg_ctl, input logic [7:0] op,
                            input logic [15:0] core, input logic [7:0] chan,
                            input logic [15:0] addr, input bit with_end);
        send_tok(1'b0, 8'h4E);
        send_tok(1'b0, 8'h21);
        send_tok(cfg_ctl, cfg);
        send_tok(1'b1, op);
        send_tok(1'b0, core[15:8]);
        send_tok(1'b0, core[7:0]);
        send_tok(1'b0, chan);
        send_tok(1'b0, addr[15:8]);
        send_tok(1'b0, addr[7:0]);
        if (with_end) send_tok(1'b1, ENDT);
    endtask

    task automatic collect(input logic [7:0] pat);
        bit held = 0;
        logic [8:0] held_v = '0;
        ngot = 0;
        for (int t = 0; t < 300 && ngot < 9; t++) begin
            out_ready = pat[t % 8];
            if (held)
                check(out_valid && {out_ctl, out_data} == held_v, "R8 hold under backpressure",
                      {22'd0, out_valid, out_ctl, out_data}, {22'd0, 1'b1, held_v});
            if (out_valid && in_ready)
                check(0, "R9 in_ready low during reply", 32'(in_ready), 32'd0);
            if (out_valid && out_ready) begin
                got[ngot] = {out_ctl, out_data};
                ngot++;
                held = 0;
            end else begin
                held = out_valid;
                held_v = {out_ctl, out_data};
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic verify_reply(input logic [15:0] core, input logic [7:0] chan, input logic [15:0] addr);
        logic [31:0] w = exp_reg(addr);
        logic [8:0] e [9];
        e[0] = {1'b0, core[15:8]}; e[1] = {1'b0, core[7:0]}; e[2] = {1'b0, chan};
        e[3] = {1'b1, ACK};
        e[4] = {1'b0, w[31:24]}; e[5] = {1'b0, w[23:16]};
        e[6] = {1'b0, w[15:8]};  e[7] = {1'b0, w[7:0]};
        e[8] = {1'b1, ENDT};
        check(ngot == 9, "R3 reply token count", 32'(ngot), 32'd9);
        for (int k = 0; k < 9; k++) begin
            if (k < 3 || k == 3 || k == 8)
                check(got[k] == e[k], "R3 reply frame/header", 32'(got[k]), 32'(e[k]));
            else
                check(got[k] == e[k], (32'(addr) < NREG) ? "R4 register value" : "R5 out-of-range zero",
                      32'(got[k]), 32'(e[k]));
        end
        check(in_ready && !out_valid, "R9 in_ready back after reply", 32'({in_ready, out_valid}), 32'b10);
    endtask

    task automatic quiet(input string req);
        bit seen = 0;
        out_ready = 1'b1;
        for (int t = 0; t < 20; t++) begin
            if (out_valid) seen = 1;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(!seen, req, 32'(seen), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: state after reset
        check(!out_valid && in_ready, "R10 reset state", 32'({out_valid, in_ready}), 32'b01);

        // R2/R3/R4/R5/R1: vector table
        for (int v = 0; v < NV; v++) begin
            send_req(VEC[v][55:48], 1'b1, 8'hC1, VEC[v][47:32], VEC[v][31:24], VEC[v][23:8], 1);
            collect(VEC[v][7:0]);
            verify_reply(VEC[v][47:32], VEC[v][31:24], VEC[v][23:8]);
        end

        // R1: configuration value sent with flag clear is data -> rejected
        send_req(8'hC2, 1'b0, 8'hC1, 16'h1111, 8'h22, 16'h0001, 1);
        quiet("R1 flagless config byte gives no reply");

        // R7: write-register token in read position
        send_req(8'hC3, 1'b1, 8'hC0, 16'h1111, 8'h22, 16'h0001, 1);
        quiet("R7 write token rejected");

        // R6: missing terminator, then stray tokens, then terminator
        send_req(8'hC2, 1'b1, 8'hC1, 16'h3333, 8'h44, 16'h0002, 0);
        send_tok(1'b0, 8'h99);
        send_tok(1'b1, 8'hC1);
        quiet("R6 missing terminator gives no reply");
        send_tok(1'b1, ENDT);
        quiet("R6 skip ends at terminator without reply");
        send_req(8'hC2, 1'b1, 8'hC1, 16'h5566, 8'h77, 16'h0006, 1);
        collect(8'hFF);
        verify_reply(16'h5566, 8'h77, 16'h0006);

        // R6: terminator as offending token resyncs at once
        send_tok(1'b0, 8'h4E);
        send_tok(1'b0, 8'h21);
        send_tok(1'b1, 8'hC3);
        send_tok(1'b1, ENDT);
        send_req(8'hC3, 1'b1, 8'hC1, 16'h0A0B, 8'h0C, 16'h0004, 1);
        collect(8'hB6);
        verify_reply(16'h0A0B, 8'h0C, 16'h0004);

        // R10: reset in the middle of a reply
        send_req(8'hC2, 1'b1, 8'hC1, 16'hFEED, 8'h11, 16'h0001, 1);
        out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R10 reset drops reply", 32'({out_valid, in_ready}), 32'b01);
        rst = 1'b0;
        quiet("R10 no reply resumes after reset");
        send_req(8'hC3, 1'b1, 8'hC1, 16'h0102, 8'h03, 16'h0002, 1);
        collect(8'h77);
        verify_reply(16'h0102, 8'h03, 16'h0002);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule